// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block produces the stream of memory addresses for a single vector load or store. Once it accepts a start pulse, it emits one address for each element of the vector, in element order. Each address is tagged with its element number. The element number is the slot in the vector register that the memory word belongs to, so words that are scattered in memory can still fill consecutive register slots.

The block has three addressing modes:
- **Unit stride:** elements are packed back to back.
- **Constant stride:** elements are a signed step apart.
- **Indexed:** each element's address is the base plus an offset taken from a separate offset stream. The same indexed mode serves gathering loads and scattering stores.

The downstream memory side takes addresses through a valid/ready handshake. It can accept one address per clock. When it stalls, the offered address stays where it is. A one-cycle completion pulse follows the acceptance of the last address.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `addr_valid_o`, `done_o` and `idx_ready_o` are low.
- R2: With `mode_i` = 2'b00 (unit stride), element i has address `base_i + i * 2^esize_i`, where `esize_i` is log2 of the element size in bytes.
- R3: With `mode_i` = 2'b01 (constant stride), element i has address `base_i + i * stride_i`. `stride_i` is a two's-complement signed value, and the address wraps modulo 2^32.
- R4: With `mode_i[1]` = 1 (indexed), element i has address `base_i + off_i`, where off_i is the i-th offset accepted on the `idx_valid_i`/`idx_ready_o` handshake. `idx_ready_o` is only ever high during an indexed access.
- R5: `elem_o` counts 0, 1, 2, … in order. Exactly VL addresses are produced, where VL = `vlen_i`. A `vlen_i` above 64 is treated as 64.
- R6: In strided or unit mode, with `addr_ready_i` held high, an address is accepted on every clock from the first element to the last.
- R7: When `addr_valid_o` is high and `addr_ready_i` is low, the next cycle shows `addr_valid_o` high with `addr_o` and `elem_o` unchanged.
- R8: `done_o` is high for exactly the cycle after the final address is accepted. With VL = 0, `done_o` is high in the cycle after the start is taken, and no address is produced.
- R9: A `start_i` that arrives while an access is in progress is ignored: the current address sequence continues unchanged and no extra `done_o` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an access (taken only when idle) |
| mode_i | input | 2 | 00 unit stride, 01 constant stride, 1x indexed |
| base_i | input | 32 | Base byte address |
| stride_i | input | 32 | Signed byte stride for mode 01 |
| esize_i | input | 2 | log2 of element size in bytes (unit mode) |
| vlen_i | input | 7 | Vector length, clamped to 64 |
| idx_valid_i | input | 1 | Offset stream valid |
| idx_ready_o | output | 1 | Offset stream ready |
| idx_i | input | 32 | Byte offset for the next indexed element |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Consumer accepts address |
| addr_o | output | 32 | Element byte address |
| elem_o | output | 6 | Destination/source element number |
| done_o | output | 1 | One-cycle pulse after the last accepted address |

## Verification
The reference model predicts every address and element number, and it checks the completion pulse on every clock against the handshakes it observes.

The corner cases the stimulus targets are:
- **Negative stride and a stride that wraps past 2^32.** A sign or carry error would show up as addresses that drift off the expected line.
- **Long stalls and irregular ready patterns.** Losing or repeating an element under backpressure would show up as changed or skipped element numbers.
- **Gaps in the offset stream.** An engine that does not wait for a valid offset would emit addresses built from stale offsets.
- **Lengths of 0, 1 and above the maximum.** A design that got these wrong would hang, emit a spurious address, or run past 64 elements.
- **A second start in the middle of an access.** A design that restarts on it would jump to the new base.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    VAG_UNIT  = 2'b00,
    VAG_STRD  = 2'b01,
    VAG_INDX  = 2'b10,
    VAG_INDX2 = 2'b11
  } vag_mode_e;

  function automatic logic vag_is_indexed(input vag_mode_e m);
    return (m == VAG_INDX) || (m == VAG_INDX2);
  endfunction

endpackage

// File: rtl/vag_seq.sv
module vag_seq
  import vag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MAXVL = 64,
  localparam int LW   = $clog2(MAXVL + 1),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [1:0]    esize_i,
  input  logic [LW-1:0] vlen_i,
  input  logic          idx_valid_i,
  input  logic [AW-1:0] idx_i,
  input  logic          load_ok_i,
  input  logic          last_acc_i,
  output logic          idx_ready_o,
  output logic          src_valid_o,
  output logic [AW-1:0] src_addr_o,
  output logic [EW-1:0] src_elem_o,
  output logic [LW-1:0] vlen_o,
  output logic [AW-1:0] base_o,
  output logic          indexed_o,
  output logic          done_o
);

  logic          busy_q, busy_d;
  logic          indexed_q, indexed_d;
  logic          done_q, done_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] stride_q, stride_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] vlen_q, vlen_d;
  logic [LW-1:0] vlen_clamped;
  logic          start_ok, more, take;

  // request side: what the sequencer can offer this cycle
  always_comb begin
    vlen_clamped = (vlen_i > LW'(MAXVL)) ? LW'(MAXVL) : vlen_i;
    start_ok     = start_i & ~busy_q;
    more         = (cnt_q < vlen_q);
    src_valid_o  = busy_q & more & (~indexed_q | idx_valid_i);
    idx_ready_o  = busy_q & indexed_q & more & load_ok_i;
    take         = src_valid_o & load_ok_i;
    src_addr_o   = indexed_q ? (base_q + idx_i) : acc_q;
    src_elem_o   = cnt_q[EW-1:0];
  end

  // next state
  always_comb begin
    busy_d    = busy_q;
    indexed_d = indexed_q;
    base_d    = base_q;
    stride_d  = stride_q;
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    vlen_d    = vlen_q;
    done_d    = 1'b0;
    if (start_ok) begin
      busy_d    = |vlen_clamped;
      done_d    = ~|vlen_clamped;
      indexed_d = vag_is_indexed(vag_mode_e'(mode_i));
      base_d    = base_i;
      acc_d     = base_i;
      stride_d  = (vag_mode_e'(mode_i) == VAG_UNIT) ? (AW'(1) << esize_i) : stride_i;
      cnt_d     = '0;
      vlen_d    = vlen_clamped;
    end else begin
      if (take) begin
        acc_d = acc_q + stride_q;
        cnt_d = cnt_q + LW'(1);
      end
      if (last_acc_i) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      indexed_q <= 1'b0;
      done_q    <= 1'b0;
      base_q    <= '0;
      stride_q  <= '0;
      acc_q     <= '0;
      cnt_q     <= '0;
      vlen_q    <= '0;
    end else begin
      busy_q    <= busy_d;
      indexed_q <= indexed_d;
      done_q    <= done_d;
      base_q    <= base_d;
      stride_q  <= stride_d;
      acc_q     <= acc_d;
      cnt_q     <= cnt_d;
      vlen_q    <= vlen_d;
    end
  end

  assign vlen_o    = vlen_q;
  assign base_o    = base_q;
  assign indexed_o = indexed_q;
  assign done_o    = done_q;

endmodule

// File: rtl/vag_oreg.sv
module vag_oreg #(
  parameter int AW = 32,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          ready_i,
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] elem_i,
  output logic          can_load_o,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [EW-1:0] elem_o
);

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic [EW-1:0] elem_q;

  always_comb begin
    can_load_o = ~valid_q | ready_i;
    if (load_i)       valid_d = 1'b1;
    else if (ready_i) valid_d = 1'b0;
    else              valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      elem_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_i) begin
        addr_q <= addr_i;
        elem_q <= elem_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign elem_o  = elem_q;

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW    = 32,
  parameter int MAXVL = 64,
  localparam int LW   = $clog2(MAXVL + 1),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [1:0]    esize_i,
  input  logic [LW-1:0] vlen_i,
  input  logic          idx_valid_i,
  output logic          idx_ready_o,
  input  logic [AW-1:0] idx_i,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_o,
  output logic [EW-1:0] elem_o,
  output logic          done_o
);

  logic          load_ok, src_valid, last_acc;
  logic [AW-1:0] src_addr;
  logic [EW-1:0] src_elem;
  logic [LW-1:0] vlen_w;
  logic [AW-1:0] base_w;
  logic          indexed_w;

  assign last_acc = addr_valid_o & addr_ready_i & ((LW'(elem_o) + LW'(1)) == vlen_w);

  vag_seq #(.AW(AW), .MAXVL(MAXVL)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .esize_i     (esize_i),
    .vlen_i      (vlen_i),
    .idx_valid_i (idx_valid_i),
    .idx_i       (idx_i),
    .load_ok_i   (load_ok),
    .last_acc_i  (last_acc),
    .idx_ready_o (idx_ready_o),
    .src_valid_o (src_valid),
    .src_addr_o  (src_addr),
    .src_elem_o  (src_elem),
    .vlen_o      (vlen_w),
    .base_o      (base_w),
    .indexed_o   (indexed_w),
    .done_o      (done_o)
  );

  vag_oreg #(.AW(AW), .EW(EW)) u_oreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (src_valid & load_ok),
    .ready_i    (addr_ready_i),
    .addr_i     (src_addr),
    .elem_i     (src_elem),
    .can_load_o (load_ok),
    .valid_o    (addr_valid_o),
    .addr_o     (addr_o),
    .elem_o     (elem_o)
  );

endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
  parameter int AW = 32,
  parameter int EW = 6,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid_o,
  input logic          addr_ready_i,
  input logic [AW-1:0] addr_o,
  input logic [EW-1:0] elem_o,
  input logic          idx_ready_o,
  input logic          done_o,
  input logic [LW-1:0] vlen_w,
  input logic [AW-1:0] base_w,
  input logic          indexed_w
);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(elem_o)); // R7

  AST_ELEM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && addr_ready_i |=> !addr_valid_o || (elem_o == EW'($past(elem_o) + 1'b1))); // R5

  AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> (LW'(elem_o) < vlen_w)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !addr_valid_o && !idx_ready_o); // R8

  AST_IDX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready_o |-> indexed_w); // R4

  AST_FIRST_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !indexed_w && (elem_o == '0) |-> (addr_o == base_w)); // R3

endmodule

bind vec_addr_gen vag_chk #(.AW(AW), .EW(EW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .elem_o       (elem_o),
  .idx_ready_o  (idx_ready_o),
  .done_o       (done_o),
  .vlen_w       (vlen_w),
  .base_w       (base_w),
  .indexed_w    (indexed_w)
);

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic [31:0] base_i, stride_i, idx_i, addr_o;
  logic [1:0]  esize_i;
  logic [6:0]  vlen_i;
  logic        idx_valid_i, idx_ready_o, addr_valid_o, addr_ready_i, done_o;
  logic [5:0]  elem_o;

  vec_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .stride_i(stride_i), .esize_i(esize_i), .vlen_i(vlen_i),
    .idx_valid_i(idx_valid_i), .idx_ready_o(idx_ready_o), .idx_i(idx_i),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
    .addr_o(addr_o), .elem_o(elem_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  int mark = 0;
  int rdy_mode = 0;
  int idx_gap = 0;
  int idx_ptr = 0;
  int idx_n = 0;
  logic [31:0] idx_arr [64];
  logic idx_hs = 1'b0;

  logic [31:0] qa[$];
  int          qe[$];
  bit          m_busy = 0, m_idx = 0, exp_done = 0, prev_fire = 0, prev_stall = 0;
  logic [31:0] prev_addr;
  logic [5:0]  prev_elem;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    bit start_acc, fire, exp_done_n;
    int vl;
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog all requirements actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    chk(done_o == exp_done, "R8 done pulse", done_o, exp_done);
    if (done_o) done_cnt++;
    exp_done_n = 0;
    if (idx_ready_o && !(m_busy && m_idx))
      chk(0, "R4 idx_ready outside indexed access", idx_ready_o, 0);
    if (prev_stall)
      chk(addr_valid_o && addr_o == prev_addr && elem_o == prev_elem,
          "R7 hold under stall", {addr_valid_o, elem_o, addr_o}, {1'b1, prev_elem, prev_addr});
    if (prev_fire && qa.size() > 0 && !m_idx && addr_ready_i)
      chk(addr_valid_o, "R6 back-to-back issue", addr_valid_o, 1);
    if (addr_valid_o) begin
      if (qa.size() == 0) chk(0, "R5 spurious address", elem_o, 0);
      else begin
        chk(elem_o == qe[0][5:0], "R5 element number", elem_o, qe[0]);
        chk(addr_o == qa[0], m_idx ? "R4 indexed address" : "R2/R3 strided address", addr_o, qa[0]);
      end
    end
    start_acc = start_i && !m_busy;
    fire = addr_valid_o && addr_ready_i;
    if (fire && qa.size() > 0) begin
      void'(qa.pop_front()); void'(qe.pop_front());
      if (qa.size() == 0 && m_busy) begin m_busy = 0; exp_done_n = 1; end
    end
    if (start_acc) begin
      vl = (vlen_i > 64) ? 64 : int'(vlen_i);
      m_idx = mode_i[1];
      for (int i = 0; i < vl; i++) begin
        if (mode_i == 2'b00)      qa.push_back(base_i + (32'(i) << esize_i));
        else if (mode_i == 2'b01) qa.push_back(base_i + 32'(i) * stride_i);
        else                      qa.push_back(base_i + idx_arr[i]);
        qe.push_back(i);
      end
      if (vl == 0) exp_done_n = 1; else m_busy = 1;
    end
    idx_hs     = idx_valid_i && idx_ready_o;
    prev_fire  = fire;
    prev_stall = addr_valid_o && !addr_ready_i;
    prev_addr  = addr_o;
    prev_elem  = elem_o;
    exp_done   = exp_done_n;
  end

  // consumer ready pattern
  initial begin
    int rc = 0;
    addr_ready_i = 1'b0;
    forever begin
      @(posedge clk); #2;
      rc++;
      case (rdy_mode)
        0:       addr_ready_i = 1'b1;
        1:       addr_ready_i = ((rc % 3) != 1) && ((rc % 7) != 2);
        default: addr_ready_i = 1'b0;
      endcase
    end
  end

  // offset stream producer
  initial begin
    idx_valid_i = 1'b0;
    idx_i = '0;
    forever begin
      @(posedge clk); #2;
      if (idx_hs) idx_ptr++;
      if (idx_ptr < idx_n && (idx_gap == 0 || (cyc % 3) != 0)) begin
        idx_valid_i = 1'b1;
        idx_i = idx_arr[idx_ptr];
      end else idx_valid_i = 1'b0;
    end
  end

  task automatic pulse_start(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                             input logic [1:0] es, input logic [6:0] vl);
    @(posedge clk); #2;
    mode_i = m; base_i = b; stride_i = s; esize_i = es; vlen_i = vl; start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                        input logic [1:0] es, input logic [6:0] vl);
    mark = done_cnt;
    pulse_start(m, b, s, es, vl);
  endtask

  task automatic wait_done();
    while (done_cnt == mark) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic load_idx(input int n, input int seed);
    for (int i = 0; i < 64; i++) idx_arr[i] = 32'((i * seed) ^ 32'h55) << 2;
    idx_ptr = 0;
    idx_n = (n > 64) ? 64 : n;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; base_i = '0; stride_i = '0;
    esize_i = '0; vlen_i = '0;
    repeat (2) @(negedge clk);
    chk(!addr_valid_o && !done_o && !idx_ready_o, "R1 outputs in reset",
        {addr_valid_o, done_o, idx_ready_o}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !done_o && !idx_ready_o, "R1 outputs after reset",
        {addr_valid_o, done_o, idx_ready_o}, 0);

    // R2 unit stride, 8-byte elements, full throughput (R6)
    rdy_mode = 0; run_op(2'b00, 32'h0000_1000, 32'h0, 2'd3, 7'd8); wait_done();
    // R2 byte elements with stalls
    rdy_mode = 1; run_op(2'b00, 32'h0000_0ff0, 32'h0, 2'd0, 7'd5); wait_done();
    // R3 negative stride
    rdy_mode = 1; run_op(2'b01, 32'h0000_2000, -32'sd24, 2'd2, 7'd17); wait_done();
    // R3 stride that wraps past 2^32
    rdy_mode = 0; run_op(2'b01, 32'hffff_ff00, 32'h7fff_fff0, 2'd1, 7'd6); wait_done();
    // R4 indexed with offset gaps and irregular ready
    load_idx(12, 37); idx_gap = 1; rdy_mode = 1;
    run_op(2'b10, 32'h0004_0000, 32'h0, 2'd0, 7'd12); wait_done();
    // R4 alternate indexed encoding, ready high
    load_idx(3, 11); idx_gap = 0; rdy_mode = 0;
    run_op(2'b11, 32'h8000_0000, 32'h0, 2'd0, 7'd3); wait_done();
    // R8 zero length
    run_op(2'b01, 32'h0000_3000, 32'd4, 2'd0, 7'd0); wait_done();
    // R5 single element and clamp above 64
    run_op(2'b00, 32'h0000_5000, 32'h0, 2'd2, 7'd1); wait_done();
    run_op(2'b00, 32'h0001_0000, 32'h0, 2'd2, 7'd100); wait_done();
    // R7 long stall before first acceptance
    rdy_mode = 2; run_op(2'b01, 32'h0000_6000, 32'd12, 2'd0, 7'd4);
    repeat (6) @(posedge clk);
    rdy_mode = 1; wait_done();
    // R9 second start during an access is ignored
    rdy_mode = 1; run_op(2'b01, 32'h0000_7000, 32'd20, 2'd0, 7'd20);
    repeat (3) @(posedge clk);
    pulse_start(2'b00, 32'h0000_dead, 32'h0, 2'd0, 7'd5);
    wait_done();
    repeat (10) @(posedge clk);
    chk(qa.size() == 0, "R9 no pending work after ignored start", qa.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule